// File: doc/BRIEF.md
# DDS Phase Accumulator with Clears

This block is the phase engine of one direct digital synthesis channel. A 32-bit frequency tuning word is added to a 32-bit phase register on every sample clock, and the phase register wraps freely. Tuning words are written into a shadow register and reach the adder only when an update strobe arrives, so a new frequency starts on a known clock edge.

There are two ways to zero the phase. A clear level forces the register to zero asynchronously and holds it there while the level stays high. An autoclear option zeroes the register for exactly one cycle on the edge that takes the update strobe. A power-down level freezes the phase and the amplitude output.

The top 12 phase bits drive a registered angle-to-amplitude stage. It uses a quarter-wave parabolic approximation and returns a signed 10-bit cosine or sine, chosen at run time.

Top module: `dds_phase_core`

## Requirements
- R1: While rst_ni is low, phase_o, amp_o, the shadow tuning word and the active tuning word are all zero.
- R2: On each clock edge where clr_i, pwr_dn_i and (update_i and autoclr_i) are all 0, phase_o becomes (phase_o + active tuning word) mod 2^32. A wrap is silent and raises no flag.
- R3: ftw_we_i=1 loads ftw_i into the shadow register. update_i=1 copies the shadow (its value before that edge) into the active register. A shadow write alone does not change the phase step.
- R4: With autoclr_i=1, the edge that samples update_i=1 sets phase_o to 0. The next edge adds the newly active tuning word to 0.
- R5: With autoclr_i=0, update_i does not disturb the phase. The strobe edge still adds the old active word, and the new word applies from the next edge.
- R6: While clr_i=1, phase_o is 0 at once, without waiting for a clock edge, and stays 0. After clr_i returns to 0, accumulation resumes from 0.
- R7: While pwr_dn_i=1, phase_o and amp_o hold their values. The shadow and active registers still load. Power-down takes priority over autoclear, and clr_i takes priority over power-down.
- R8: amp_o is registered. After an edge with pwr_dn_i=0, amp_o = f(P) for the phase P held before that edge, where p = P[31:20] and u = p when sine_sel_i=1, or u = (p+1024) mod 4096 when sine_sel_i=0 (cosine). With d = u[11:10] and k = u[9:0], m = k if d is even, else 1024-k. Then s = floor(m*(2048-m)*511 / 2^20), and amp_o = s for d<2 and -s for d>=2, in 10-bit two's complement.
- R9: Corner values: cosine at p=0 is +511, cosine at p=1024 is 0, and cosine at p=2048 is -511 (10'h201). Sine at p=0 is 0, sine at p=1024 is +511, and sine at p=3072 is -511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ftw_i | input | 32 | Tuning word to write into the shadow register |
| ftw_we_i | input | 1 | Shadow register write enable |
| update_i | input | 1 | Copies the shadow register into the active register |
| autoclr_i | input | 1 | Zeroes the phase on the update edge |
| clr_i | input | 1 | Level asynchronous phase clear |
| sine_sel_i | input | 1 | 0 selects cosine, 1 selects sine |
| pwr_dn_i | input | 1 | Freezes the phase and the amplitude |
| phase_o | output | 32 | Phase accumulator value |
| amp_o | output | 10 | Signed amplitude |

## Verification
The bench drives the update strobe with and without autoclear. A design that zeroed the phase one edge late, or held it at zero for two cycles, would offset every later phase value. A tuning word of all ones steps the phase down and wraps it, which shows up a carry that leaks or saturates. The bench raises the asynchronous clear between clock edges and samples the phase before the next edge, so a clear that waits for the clock is caught. Power-down is combined with a strobe to show that the frozen phase picks up the buffered word on release. The quadrant corners of both cosine and sine are checked to expose a swapped reflection or a sign error.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FTW_W_DEF   = 32;
  localparam int PHASE_W_DEF = 12;
  localparam int AMP_W_DEF   = 10;

  typedef enum logic [1:0] {
    ACC_RUN  = 2'd0,
    ACC_HOLD = 2'd1,
    ACC_ZERO = 2'd2
  } acc_op_e;
endpackage

// File: rtl/dds_ftw_buffer.sv
module dds_ftw_buffer #(
  parameter int FTW_W = dds_pkg::FTW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic             we_i,
  input  logic             update_i,
  output logic [FTW_W-1:0] active_o
);
  logic [FTW_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i)     shadow_q <= ftw_i;
      if (update_i) active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

  p_active_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(active_q));
  p_active_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> active_q == $past(shadow_q));
endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum
  import dds_pkg::*;
#(
  parameter int FTW_W = dds_pkg::FTW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pwr_dn_i,
  input  logic             update_i,
  input  logic             autoclr_i,
  input  logic [FTW_W-1:0] step_i,
  output logic [FTW_W-1:0] acc_o
);
  logic [FTW_W-1:0] acc_q;
  acc_op_e          op;

  // power-down wins over autoclear
  always_comb begin
    if (pwr_dn_i)                    op = ACC_HOLD;
    else if (update_i && autoclr_i)  op = ACC_ZERO;
    else                             op = ACC_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else begin
      case (op)
        ACC_ZERO: acc_q <= '0;
        ACC_HOLD: acc_q <= acc_q;
        default:  acc_q <= acc_q + step_i;
      endcase
    end
  end

  assign acc_o = acc_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!pwr_dn_i && !(update_i && autoclr_i)) |=> acc_q == $past(acc_q) + $past(step_i));
  p_autoclr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!pwr_dn_i && update_i && autoclr_i) |=> acc_q == '0);
  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    pwr_dn_i |=> $stable(acc_q));
  p_clr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> acc_q == '0);
endmodule

// File: rtl/dds_amp_stage.sv
module dds_amp_stage #(
  parameter int PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int AMP_W   = dds_pkg::AMP_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sine_sel_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [AMP_W-1:0]   amp_o
);
  localparam int QB      = PHASE_W - 2;
  localparam int QUARTER = 1 << QB;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
  localparam int PROD_W  = 2 * (QB + 2) + AMP_W;

  logic [PHASE_W-1:0] u;
  logic [1:0]         quad;
  logic [QB-1:0]      k;
  logic [QB+1:0]      m, m_rest;
  logic [PROD_W-1:0]  prod;
  logic [AMP_W-1:0]   mag, amp_d, amp_q;

  // cosine is sine advanced by one quarter turn
  always_comb begin
    u      = sine_sel_i ? phase_i : phase_i + PHASE_W'(QUARTER);
    quad   = u[PHASE_W-1 -: 2];
    k      = u[QB-1:0];
    m      = quad[0] ? (QB+2)'(QUARTER) - {2'b00, k} : {2'b00, k};
    m_rest = (QB+2)'(2 * QUARTER) - m;
    prod   = PROD_W'(m) * PROD_W'(m_rest) * PROD_W'(AMP_MAX);
    mag    = AMP_W'(prod >> (2 * QB));
    amp_d  = quad[1] ? -mag : mag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   amp_q <= '0;
    else if (en_i) amp_q <= amp_d;
  end

  assign amp_o = amp_q;

  p_cos_origin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sine_sel_i && phase_i == '0) |=> amp_q == AMP_W'(AMP_MAX));
  p_sin_origin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sine_sel_i && phase_i == '0) |=> amp_q == '0);
  p_amp_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(amp_q));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int FTW_W   = dds_pkg::FTW_W_DEF,
  parameter int PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int AMP_W   = dds_pkg::AMP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic             ftw_we_i,
  input  logic             update_i,
  input  logic             autoclr_i,
  input  logic             clr_i,
  input  logic             sine_sel_i,
  input  logic             pwr_dn_i,
  output logic [FTW_W-1:0] phase_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [FTW_W-1:0] step;
  logic [FTW_W-1:0] acc;

  dds_ftw_buffer #(.FTW_W(FTW_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ftw_i    (ftw_i),
    .we_i     (ftw_we_i),
    .update_i (update_i),
    .active_o (step)
  );

  dds_phase_accum #(.FTW_W(FTW_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .pwr_dn_i  (pwr_dn_i),
    .update_i  (update_i),
    .autoclr_i (autoclr_i),
    .step_i    (step),
    .acc_o     (acc)
  );

  dds_amp_stage #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_amp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!pwr_dn_i),
    .sine_sel_i (sine_sel_i),
    .phase_i    (acc[FTW_W-1 -: PHASE_W]),
    .amp_o      (amp_o)
  );

  assign phase_o = acc;

  initial begin
    a_cfg_r8: assert (PHASE_W >= 3 && PHASE_W <= FTW_W && AMP_W >= 2);
  end
endmodule

// File: tb/dds_phase_core_tb.sv
`timescale 1ns/1ps
module dds_phase_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ftw_i = '0;
  logic        ftw_we_i = 0, update_i = 0, autoclr_i = 0, clr_i = 0;
  logic        sine_sel_i = 0, pwr_dn_i = 0;
  logic [31:0] phase_o;
  logic [9:0]  amp_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_acc = '0, m_shadow = '0, m_active = '0;
  logic [9:0]  m_amp = '0;

  // ftw, autoclr, sine_sel, cycles
  localparam logic [41:0] VECS [6] = '{
    {32'h0100_0000, 1'b0, 1'b0, 8'd6},
    {32'h1234_5678, 1'b1, 1'b1, 8'd8},
    {32'hFFFF_FFFF, 1'b0, 1'b0, 8'd5},
    {32'h8000_0000, 1'b1, 1'b0, 8'd4},
    {32'h4000_0000, 1'b1, 1'b1, 8'd5},
    {32'h0003_0001, 1'b0, 1'b1, 8'd10}
  };

  always #4 clk_i = ~clk_i;

  dds_phase_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ftw_i(ftw_i), .ftw_we_i(ftw_we_i),
    .update_i(update_i), .autoclr_i(autoclr_i), .clr_i(clr_i),
    .sine_sel_i(sine_sel_i), .pwr_dn_i(pwr_dn_i), .phase_o(phase_o), .amp_o(amp_o)
  );

  function automatic logic [9:0] amp_ref(input logic [11:0] p, input logic sn);
    int u, d, k, m;
    longint s;
    u = sn ? int'(p) : (int'(p) + 1024) % 4096;
    d = u / 1024;
    k = u % 1024;
    m = (d % 2 == 0) ? k : 1024 - k;
    s = (longint'(m) * longint'(2048 - m) * 511) >>> 20;
    return (d < 2) ? 10'(s) : 10'(-s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [31:0] nacc;
    logic [9:0]  namp;
    @(posedge clk_i);
    namp = pwr_dn_i ? m_amp : amp_ref(m_acc[31:20], sine_sel_i);
    if (clr_i)                        nacc = '0;
    else if (pwr_dn_i)                nacc = m_acc;
    else if (update_i && autoclr_i)   nacc = '0;
    else                              nacc = m_acc + m_active;
    if (update_i) m_active = m_shadow;
    if (ftw_we_i) m_shadow = ftw_i;
    m_acc = nacc;
    m_amp = namp;
    @(negedge clk_i);
    chk(tag, phase_o, m_acc);
    chk({tag, "/R8"}, {22'd0, amp_o}, {22'd0, m_amp});
  endtask

  task automatic load(input logic [31:0] w, input string tag);
    ftw_i = w; ftw_we_i = 1;
    step("R3");
    ftw_we_i = 0; update_i = 1;
    step(tag);
    update_i = 0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", phase_o, 32'd0);
    chk("R1", {22'd0, amp_o}, 32'd0);
    rst_ni = 1;
    step("R1");  // active word is zero: phase stays at 0

    for (int i = 0; i < 6; i++) begin
      autoclr_i  = VECS[i][9];
      sine_sel_i = VECS[i][8];
      load(VECS[i][41:10], VECS[i][9] ? "R4" : "R5");
      for (int c = 0; c < int'(VECS[i][7:0]); c++) step("R2");
    end

    // R3: shadow write without update keeps the old step
    ftw_i = 32'h0000_0100; ftw_we_i = 1;
    step("R3");
    ftw_we_i = 0;
    repeat (3) step("R3");

    // R9: quadrant corners
    autoclr_i = 1; sine_sel_i = 0;
    ftw_i = 32'h4000_0000; ftw_we_i = 1; step("R3");
    ftw_we_i = 0; update_i = 1; step("R4");
    update_i = 0;
    chk("R4", phase_o, 32'd0);
    step("R9"); chk("R9 cos0",    {22'd0, amp_o}, 32'd511);
    step("R9"); chk("R9 cos1024", {22'd0, amp_o}, 32'd0);
    step("R9"); chk("R9 cos2048", {22'd0, amp_o}, 32'h201);
    sine_sel_i = 1;
    step("R9"); chk("R9 sin3072", {22'd0, amp_o}, 32'h201);
    step("R9"); chk("R9 sin0",    {22'd0, amp_o}, 32'd0);
    step("R9"); chk("R9 sin1024", {22'd0, amp_o}, 32'd511);

    // R6: asynchronous clear between edges
    ftw_i = 32'h0ABC_DEF1; ftw_we_i = 1; step("R3");
    ftw_we_i = 0; autoclr_i = 0; update_i = 1; step("R5");
    update_i = 0;
    step("R2"); step("R2");
    #1;
    clr_i = 1;
    #1;
    m_acc = '0;
    chk("R6 async", phase_o, 32'd0);
    @(negedge clk_i);
    step("R6"); step("R6");
    clr_i = 0;
    step("R6"); step("R6");

    // R7: power-down freezes, buffer still loads
    pwr_dn_i = 1;
    step("R7"); step("R7");
    ftw_i = 32'h0000_1000; ftw_we_i = 1; step("R7");
    ftw_we_i = 0; update_i = 1; autoclr_i = 1; step("R7");
    update_i = 0; autoclr_i = 0;
    step("R7");
    pwr_dn_i = 0;
    repeat (3) step("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule